// File: doc/BRIEF.md
# Committed Receive Frame Buffer

This block sits between the receive side of an Ethernet MAC and a host. The MAC delivers each frame as a byte stream with start and end markers and, on the last byte, a flag telling whether the frame had a legal length and a valid CRC. The block writes accepted frames into a circular byte store. It keeps a small queue of descriptors, one per held frame, each with a length and a status. It discards rejected frames by rewinding its write pointer to the end of the last held frame.

The host sees exactly one held frame at a time, the oldest. It can read the frame's status word, its length word and its data through three fixed word addresses. It can also use a single sequential port that returns status, then length, then the data. The bytes of every held frame are protected from new traffic until the host releases that frame. The host releases a frame in one of three ways: it reads the frame to its last byte, it pulses a skip control, or it reads the receive-event register partway through the frame while a further frame is waiting. The last of these is called an implied skip.

The block raises a one-cycle interrupt for each accepted good frame and an early-receive pulse when a frame starts. The early pulse is withheld while a frame waits for the host. A one-cycle overflow pulse reports every frame lost for lack of byte space or of a descriptor slot.

Top module: `rxq_frame_store`

## Requirements
- R1: After reset, and whenever no frame is held, reads of addresses 0x400, 0x402, 0x404 and 0x000 return 0, and irq_rx_ok, irq_early and rx_overflow are low.
- R2: The status word of the visible frame has bit 0 = frame was good, bit 1 = CRC bytes retained, and all other bits 0. The length word is the number of stored bytes.
- R3: Successive host reads of address 0x000 return the status word, then the length word, then the data words in order.
- R4: Reads of address 0x404 return data words little-endian: the earlier byte is in bits 7:0 and the next byte is in bits 15:8. When only one byte remains, bits 15:8 are 0.
- R5: The data read that reaches the last stored byte releases the frame. The next held frame, in arrival order, then becomes visible.
- R6: A pulse on host_skip releases the visible frame whether none, part or most of it has been read.
- R7: A pulse on host_evt_rd releases the visible frame only when it has been partly read (data or sequential-port header) and at least one further frame is held. Otherwise it changes nothing.
- R8: With cfg_keep_crc low, the last 4 bytes of each frame are not stored, and a frame of 4 or fewer bytes is discarded. With cfg_keep_crc high, all bytes are stored.
- R9: A good frame is accepted only when cfg_accept_good is high, and a bad frame only when cfg_accept_bad is high. A rejected frame leaves no trace visible to the host.
- R10: Bytes of held frames are never overwritten. A frame longer than 2^BUF_AW minus the bytes already held is dropped, and rx_overflow pulses for one cycle in the cycle after its last byte.
- R11: When DESC_DEPTH frames are already held, an incoming frame is dropped and rx_overflow pulses in the cycle after its last byte.
- R12: irq_rx_ok pulses for one cycle, in the cycle after the last byte, for each accepted good frame while cfg_ok_irq_en is high, and never otherwise.
- R13: irq_early pulses for one cycle, in the cycle after a start byte, when cfg_early_irq_en is high and no frame is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| rx_data | input | 8 | Receive byte |
| rx_good | input | 1 | On the last byte: legal length and valid CRC |
| cfg_keep_crc | input | 1 | Retain the 4 CRC bytes |
| cfg_accept_good | input | 1 | Accept good frames |
| cfg_accept_bad | input | 1 | Accept bad frames |
| cfg_ok_irq_en | input | 1 | Enable the good-frame interrupt |
| cfg_early_irq_en | input | 1 | Enable the early-receive pulse |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 12 | Host read address |
| host_rdata | output | 16 | Host read data, valid while host_rd is high |
| host_skip | input | 1 | Release the visible frame |
| host_evt_rd | input | 1 | Host read of the receive-event register |
| irq_rx_ok | output | 1 | Good-frame interrupt pulse |
| irq_early | output | 1 | Early-receive pulse |
| rx_overflow | output | 1 | Frame dropped for lack of space or slot |

## Verification
The bench builds the block with BUF_AW = 7, a 128-byte store, and DESC_DEPTH = 2. With these values, a frame too long for the space left beside a held frame, and a third frame arriving while two are held, can both be produced with a few short frames. The small store also makes the read and write pointers wrap many times over a run of mixed-length traffic, which checks that release and rewinding stay correct across the wrap boundary. Odd and even lengths, CRC retention on and off, and both read paths are mixed so that padding and sequential-port ordering are each reached.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef struct packed {
        logic [15:0] len;
        logic        good;
        logic        crc_kept;
    } frame_desc_t;

    typedef enum logic [1:0] {
        PH_STATUS = 2'd0,
        PH_LENGTH = 2'd1,
        PH_DATA   = 2'd2
    } io_phase_e;

    localparam logic [11:0] ADDR_SEQ    = 12'h000;
    localparam logic [11:0] ADDR_STATUS = 12'h400;
    localparam logic [11:0] ADDR_LENGTH = 12'h402;
    localparam logic [11:0] ADDR_DATA   = 12'h404;

endpackage

// File: rtl/rxq_byte_ram.sv
module rxq_byte_ram #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata_lo,
    output logic [7:0]    rdata_hi
);
    localparam int DEPTH = 1 << AW;

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] raddr_nx;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // The second byte of a word wraps with the circular store.
    assign raddr_nx = raddr + 1'b1;
    assign rdata_lo = mem[raddr];
    assign rdata_hi = mem[raddr_nx];
endmodule

// File: rtl/rxq_desc_fifo.sv
module rxq_desc_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH_D = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        push,
    input  frame_desc_t push_desc,
    input  logic        pop,
    output frame_desc_t head,
    output logic        empty,
    output logic        full,
    output logic        multi
);
    localparam int PW = (DEPTH_D > 1) ? $clog2(DEPTH_D) : 1;
    localparam int CW = $clog2(DEPTH_D + 1);
    localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH_D - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH_D);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_state_t;

    fifo_state_t s_d, s_q;
    frame_desc_t slots [DEPTH_D];
    logic        do_push, do_pop;

    assign empty = (s_q.cnt == '0);
    assign full  = (s_q.cnt == FULL_CNT);
    assign multi = (s_q.cnt > CW'(1));
    assign head  = slots[s_q.rp];

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_comb begin
        s_d = s_q;
        if (do_push) begin
            s_d.wp = (s_q.wp == LAST_IDX) ? '0 : s_q.wp + 1'b1;
        end
        if (do_pop) begin
            s_d.rp = (s_q.rp == LAST_IDX) ? '0 : s_q.rp + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            slots[s_q.wp] <= push_desc;
        end
    end
endmodule

// File: rtl/rxq_ingress.sv
module rxq_ingress
    import rxq_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic          rx_sof,
    input  logic          rx_eof,
    input  logic [7:0]    rx_data,
    input  logic          rx_good,
    input  logic          cfg_keep_crc,
    input  logic          cfg_accept_good,
    input  logic          cfg_accept_bad,
    input  logic          cfg_ok_irq_en,
    input  logic          desc_full,
    input  logic [AW:0]   rd_base,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [7:0]    mem_wdata,
    output logic          desc_push,
    output frame_desc_t   desc_out,
    output logic [AW:0]   wr_ptr,
    output logic          irq_ok,
    output logic          ovf
);
    localparam logic [AW:0] DEPTH_P = (AW + 1)'(1) << AW;

    typedef struct packed {
        logic        in_frame;
        logic        drop;
        logic [AW:0] wr_ptr;
        logic [AW:0] commit_ptr;
        logic [15:0] cnt;
        logic        irq;
        logic        ovf;
    } ing_state_t;

    ing_state_t  s_d, s_q;
    logic [AW:0] base_wr, used;
    logic [15:0] base_cnt, cnt_n, stored_len;
    logic        base_drop, drop_n, active, len_ok, type_ok;

    assign mem_waddr = base_wr[AW-1:0];
    assign mem_wdata = rx_data;
    assign wr_ptr    = s_q.wr_ptr;
    assign irq_ok    = s_q.irq;
    assign ovf       = s_q.ovf;

    always_comb begin
        s_d        = s_q;
        s_d.irq    = 1'b0;
        s_d.ovf    = 1'b0;
        mem_we     = 1'b0;
        desc_push  = 1'b0;
        desc_out   = '0;
        // A start byte abandons any unfinished frame.
        base_wr    = rx_sof ? s_q.commit_ptr : s_q.wr_ptr;
        base_cnt   = rx_sof ? 16'd0 : s_q.cnt;
        base_drop  = rx_sof ? 1'b0 : s_q.drop;
        active     = rx_valid && (rx_sof || s_q.in_frame);
        used       = base_wr - rd_base;
        drop_n     = base_drop || (used == DEPTH_P);
        cnt_n      = base_cnt + 16'd1;
        stored_len = cfg_keep_crc ? cnt_n : cnt_n - 16'd4;
        len_ok     = cfg_keep_crc || (cnt_n > 16'd4);
        type_ok    = rx_good ? cfg_accept_good : cfg_accept_bad;

        if (active) begin
            mem_we       = !drop_n;
            s_d.in_frame = 1'b1;
            s_d.drop     = drop_n;
            s_d.cnt      = cnt_n;
            s_d.wr_ptr   = drop_n ? base_wr : base_wr + 1'b1;
            if (rx_eof) begin
                s_d.in_frame = 1'b0;
                if (!drop_n && !desc_full && type_ok && len_ok) begin
                    desc_push         = 1'b1;
                    desc_out.len      = stored_len;
                    desc_out.good     = rx_good;
                    desc_out.crc_kept = cfg_keep_crc;
                    s_d.commit_ptr    = s_q.commit_ptr + stored_len[AW:0];
                    s_d.irq           = rx_good && cfg_ok_irq_en;
                end
                s_d.wr_ptr = desc_push ? s_d.commit_ptr : s_q.commit_ptr;
                s_d.ovf    = drop_n || desc_full;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/rxq_frame_store.sv
module rxq_frame_store
    import rxq_pkg::*;
#(
    parameter int BUF_AW     = 12,
    parameter int DESC_DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic        rx_sof,
    input  logic        rx_eof,
    input  logic [7:0]  rx_data,
    input  logic        rx_good,
    input  logic        cfg_keep_crc,
    input  logic        cfg_accept_good,
    input  logic        cfg_accept_bad,
    input  logic        cfg_ok_irq_en,
    input  logic        cfg_early_irq_en,
    input  logic        host_rd,
    input  logic [11:0] host_addr,
    output logic [15:0] host_rdata,
    input  logic        host_skip,
    input  logic        host_evt_rd,
    output logic        irq_rx_ok,
    output logic        irq_early,
    output logic        rx_overflow
);
    typedef struct packed {
        logic [BUF_AW:0] rd_base;
        logic [15:0]     rd_off;
        io_phase_e       phase;
        logic            early;
    } host_state_t;

    host_state_t     s_d, s_q;
    frame_desc_t     head, push_desc;
    logic            desc_empty, desc_full, desc_multi, desc_push, release_now;
    logic            mem_we, pending, data_rd, hi_ok, last_word, part_read;
    logic [BUF_AW-1:0] mem_waddr, raddr;
    logic [7:0]      mem_wdata, ram_lo, ram_hi;
    logic [BUF_AW:0] ing_wr_ptr, rd_base_q;
    logic [15:0]     status_w, data_w;

    rxq_ingress #(.AW(BUF_AW)) u_ingress (
        .clk             (clk),
        .rst_n           (rst_n),
        .rx_valid        (rx_valid),
        .rx_sof          (rx_sof),
        .rx_eof          (rx_eof),
        .rx_data         (rx_data),
        .rx_good         (rx_good),
        .cfg_keep_crc    (cfg_keep_crc),
        .cfg_accept_good (cfg_accept_good),
        .cfg_accept_bad  (cfg_accept_bad),
        .cfg_ok_irq_en   (cfg_ok_irq_en),
        .desc_full       (desc_full),
        .rd_base         (rd_base_q),
        .mem_we          (mem_we),
        .mem_waddr       (mem_waddr),
        .mem_wdata       (mem_wdata),
        .desc_push       (desc_push),
        .desc_out        (push_desc),
        .wr_ptr          (ing_wr_ptr),
        .irq_ok          (irq_rx_ok),
        .ovf             (rx_overflow)
    );

    rxq_byte_ram #(.AW(BUF_AW)) u_ram (
        .clk      (clk),
        .we       (mem_we),
        .waddr    (mem_waddr),
        .wdata    (mem_wdata),
        .raddr    (raddr),
        .rdata_lo (ram_lo),
        .rdata_hi (ram_hi)
    );

    rxq_desc_fifo #(.DEPTH_D(DESC_DEPTH)) u_desc (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (desc_push),
        .push_desc (push_desc),
        .pop       (release_now),
        .head      (head),
        .empty     (desc_empty),
        .full      (desc_full),
        .multi     (desc_multi)
    );

    assign rd_base_q = s_q.rd_base;
    assign irq_early = s_q.early;
    assign pending   = !desc_empty;
    assign raddr     = s_q.rd_base[BUF_AW-1:0] + s_q.rd_off[BUF_AW-1:0];
    assign status_w  = {14'd0, head.crc_kept, head.good};
    assign hi_ok     = ({1'b0, s_q.rd_off} + 17'd1) < {1'b0, head.len};
    assign last_word = ({1'b0, s_q.rd_off} + 17'd2) >= {1'b0, head.len};
    assign data_w    = {hi_ok ? ram_hi : 8'h00, ram_lo};
    assign part_read = (s_q.rd_off != 16'd0) || (s_q.phase != PH_STATUS);

    always_comb begin
        s_d        = s_q;
        host_rdata = 16'd0;
        data_rd    = 1'b0;
        if (host_rd && pending) begin
            case (host_addr)
                ADDR_STATUS: host_rdata = status_w;
                ADDR_LENGTH: host_rdata = head.len;
                ADDR_DATA: begin
                    host_rdata = data_w;
                    data_rd    = 1'b1;
                end
                ADDR_SEQ: begin
                    case (s_q.phase)
                        PH_STATUS: begin
                            host_rdata = status_w;
                            s_d.phase  = PH_LENGTH;
                        end
                        PH_LENGTH: begin
                            host_rdata = head.len;
                            s_d.phase  = PH_DATA;
                        end
                        default: begin
                            host_rdata = data_w;
                            data_rd    = 1'b1;
                        end
                    endcase
                end
                default: host_rdata = 16'd0;
            endcase
        end
        if (data_rd) begin
            s_d.rd_off = s_q.rd_off + 16'd2;
        end
        release_now = pending && ((data_rd && last_word) || host_skip ||
                                  (host_evt_rd && desc_multi && part_read));
        if (release_now) begin
            s_d.rd_base = s_q.rd_base + head.len[BUF_AW:0];
            s_d.rd_off  = 16'd0;
            s_d.phase   = PH_STATUS;
        end
        s_d.early = cfg_early_irq_en && rx_valid && rx_sof && !pending;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{rd_base: '0, rd_off: '0, phase: PH_STATUS, early: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/rxq_frame_store_chk.sv
module rxq_frame_store_chk #(
    parameter int BUF_AW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          host_rd,
    input logic [15:0]   host_rdata,
    input logic          host_skip,
    input logic          desc_empty,
    input logic [BUF_AW:0] wr_ptr,
    input logic [BUF_AW:0] rd_base,
    input logic          rx_valid,
    input logic          rx_sof,
    input logic          rx_eof,
    input logic          rx_good,
    input logic          cfg_ok_irq_en,
    input logic          cfg_early_irq_en,
    input logic          irq_rx_ok,
    input logic          irq_early,
    input logic          rx_overflow
);
    localparam logic [BUF_AW:0] DEPTH_P = (BUF_AW + 1)'(1) << BUF_AW;
    logic [BUF_AW:0] used;
    assign used = wr_ptr - rd_base;

    assert_idle_reads_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && desc_empty) |-> (host_rdata == 16'd0));

    assert_skip_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_skip && !desc_empty) |=> (rd_base != $past(rd_base)));

    assert_no_overwrite_R10: assert property (@(posedge clk) disable iff (!rst_n)
        used <= DEPTH_P);

    assert_overflow_at_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overflow |-> $past(rx_valid && rx_eof));

    assert_ok_irq_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx_ok |-> $past(rx_valid && rx_eof && rx_good && cfg_ok_irq_en));

    assert_early_gate_R13: assert property (@(posedge clk) disable iff (!rst_n)
        irq_early |-> $past(rx_valid && rx_sof && cfg_early_irq_en && desc_empty));
endmodule

bind rxq_frame_store rxq_frame_store_chk #(.BUF_AW(BUF_AW)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .host_rd          (host_rd),
    .host_rdata       (host_rdata),
    .host_skip        (host_skip),
    .desc_empty       (desc_empty),
    .wr_ptr           (ing_wr_ptr),
    .rd_base          (rd_base_q),
    .rx_valid         (rx_valid),
    .rx_sof           (rx_sof),
    .rx_eof           (rx_eof),
    .rx_good          (rx_good),
    .cfg_ok_irq_en    (cfg_ok_irq_en),
    .cfg_early_irq_en (cfg_early_irq_en),
    .irq_rx_ok        (irq_rx_ok),
    .irq_early        (irq_early),
    .rx_overflow      (rx_overflow)
);

// File: tb/rxq_frame_store_tb.sv
module rxq_frame_store_tb;
    localparam int AW    = 7;
    localparam int DDEP  = 2;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_good = 0;
    logic [7:0] rx_data = 0;
    logic cfg_keep_crc = 0, cfg_accept_good = 1, cfg_accept_bad = 0;
    logic cfg_ok_irq_en = 1, cfg_early_irq_en = 0;
    logic host_rd = 0, host_skip = 0, host_evt_rd = 0;
    logic [11:0] host_addr = 0;
    logic [15:0] host_rdata;
    logic irq_rx_ok, irq_early, rx_overflow;

    int n_chk = 0, n_err = 0, n_irq = 0, n_early = 0, n_ovf = 0;
    bit done = 0;

    // scoreboard: bytes of held frames, and per-frame length and status
    logic [7:0]  exp_b[$];
    int          flen_q[$];
    logic [15:0] fstat_q[$];
    int          cur_off = 0, io_ph = 0;

    always #5 clk = ~clk;

    rxq_frame_store #(.BUF_AW(AW), .DESC_DEPTH(DDEP)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_eof(rx_eof), .rx_data(rx_data), .rx_good(rx_good),
        .cfg_keep_crc(cfg_keep_crc), .cfg_accept_good(cfg_accept_good),
        .cfg_accept_bad(cfg_accept_bad), .cfg_ok_irq_en(cfg_ok_irq_en),
        .cfg_early_irq_en(cfg_early_irq_en), .host_rd(host_rd),
        .host_addr(host_addr), .host_rdata(host_rdata), .host_skip(host_skip),
        .host_evt_rd(host_evt_rd), .irq_rx_ok(irq_rx_ok), .irq_early(irq_early),
        .rx_overflow(rx_overflow));

    always @(negedge clk) begin
        if (irq_rx_ok)   n_irq++;
        if (irq_early)   n_early++;
        if (rx_overflow) n_ovf++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int pend_bytes();
        int s = 0;
        foreach (flen_q[i]) s += flen_q[i];
        return s;
    endfunction

    function automatic void model_release();
        int left = flen_q[0] - cur_off;
        for (int i = 0; i < left; i++) void'(exp_b.pop_front());
        void'(flen_q.pop_front());
        void'(fstat_q.pop_front());
        cur_off = 0;
        io_ph = 0;
    endfunction

    function automatic logic [15:0] model_data();
        logic [15:0] w;
        w[7:0]  = exp_b.pop_front();
        cur_off++;
        w[15:8] = 8'h00;
        if (cur_off < flen_q[0]) begin
            w[15:8] = exp_b.pop_front();
            cur_off++;
        end
        if (cur_off >= flen_q[0]) model_release();
        return w;
    endfunction

    function automatic logic [15:0] model_read(input logic [11:0] a);
        if (flen_q.size() == 0) return 16'd0;
        case (a)
            12'h400: return fstat_q[0];
            12'h402: return 16'(flen_q[0]);
            12'h404: return model_data();
            12'h000: begin
                if (io_ph == 0) begin io_ph = 1; return fstat_q[0]; end
                if (io_ph == 1) begin io_ph = 2; return 16'(flen_q[0]); end
                return model_data();
            end
            default: return 16'd0;
        endcase
    endfunction

    // driver: sends one frame and pushes what should be held into the scoreboard
    task automatic send(input int n, input bit good, input int seed);
        int  ir0 = n_irq, ev0 = n_early, ov0 = n_ovf;
        bit  drop  = (pend_bytes() + n) > DEPTH;
        bit  full  = flen_q.size() >= DDEP;
        int  len   = cfg_keep_crc ? n : n - 4;
        bit  lenok = cfg_keep_crc ? (n > 0) : (n > 4);
        bit  typok = good ? cfg_accept_good : cfg_accept_bad;
        bit  acc   = !drop && !full && typok && lenok;
        bit  e_ear = cfg_early_irq_en && (flen_q.size() == 0);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1; rx_sof = (i == 0); rx_eof = (i == n - 1);
            rx_data = 8'(seed + i * 7); rx_good = good;
        end
        @(negedge clk);
        rx_valid = 0; rx_sof = 0; rx_eof = 0;
        @(negedge clk); #1;
        chk((n_irq - ir0) == int'(acc && good && cfg_ok_irq_en), "R12 irq", n_irq - ir0,
            int'(acc && good && cfg_ok_irq_en));
        chk((n_ovf - ov0) == int'(drop || full), full ? "R11 ovf" : "R10 ovf",
            n_ovf - ov0, int'(drop || full));
        chk((n_early - ev0) == int'(e_ear), "R13 early", n_early - ev0, int'(e_ear));
        if (acc) begin
            for (int i = 0; i < len; i++) exp_b.push_back(8'(seed + i * 7));
            flen_q.push_back(len);
            fstat_q.push_back({14'd0, cfg_keep_crc, good});
        end
    endtask

    // monitor read: pops the scoreboard and compares with the port
    task automatic rd(input logic [11:0] a, input string req);
        logic [15:0] e, got;
        e = model_read(a);
        @(negedge clk);
        host_rd = 1; host_addr = a;
        #1 got = host_rdata;
        @(posedge clk); #1 host_rd = 0;
        chk(got == e, req, got, e);
    endtask

    task automatic pulse_skip();
        @(negedge clk); host_skip = 1;
        @(posedge clk); #1 host_skip = 0;
        if (flen_q.size() != 0) model_release();
    endtask

    task automatic pulse_evt();
        bit impl = (flen_q.size() >= 2) && (cur_off != 0 || io_ph != 0);
        @(negedge clk); host_evt_rd = 1;
        @(posedge clk); #1 host_evt_rd = 0;
        if (impl) model_release();
    endtask

    task automatic drain(input bit seq, input string req);
        while (flen_q.size() != 0) begin
            int k = (flen_q[0] + 1) / 2;
            rd(seq ? 12'h000 : 12'h400, req);
            rd(seq ? 12'h000 : 12'h402, req);
            for (int i = 0; i < k; i++) rd(seq ? 12'h000 : 12'h404, req);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(!irq_rx_ok && !irq_early && !rx_overflow, "R1 outputs", 0, 0);
        rd(12'h400, "R1 status idle"); rd(12'h402, "R1 length idle");
        rd(12'h404, "R1 data idle");   rd(12'h000, "R1 seq idle");

        // R3 R8 R5: CRC stripped, read through the sequential port
        send(10, 1, 8'h11);
        rd(12'h000, "R3 status"); rd(12'h000, "R3 length");
        for (int i = 0; i < 3; i++) rd(12'h000, "R3 data");
        rd(12'h400, "R5 released after last word");

        // R2 R4: CRC kept, odd length, memory-mode data
        cfg_keep_crc = 1;
        send(9, 1, 8'h40);
        rd(12'h400, "R2 status"); rd(12'h402, "R2 length");
        for (int i = 0; i < 5; i++) rd(12'h404, "R4 data word");
        rd(12'h402, "R5 empty after read");

        // R8 short frame discarded without CRC
        cfg_keep_crc = 0;
        send(4, 1, 8'h20);
        rd(12'h402, "R8 short frame dropped");

        // R9 acceptance
        send(12, 0, 8'h33);
        rd(12'h402, "R9 bad rejected");
        cfg_accept_bad = 1;
        send(12, 0, 8'h35);
        rd(12'h400, "R9 bad kept status"); rd(12'h402, "R9 bad kept length");
        drain(0, "R9 bad data");
        cfg_accept_good = 0;
        send(12, 1, 8'h37);
        rd(12'h402, "R9 good rejected");
        cfg_accept_good = 1; cfg_accept_bad = 0;

        // R6 skip partway and with nothing read
        send(20, 1, 8'h50); send(12, 1, 8'h60);
        rd(12'h404, "R6 partial"); pulse_skip();
        rd(12'h402, "R6 next visible"); pulse_skip();
        rd(12'h400, "R6 empty after skip");

        // R7 implied skip
        send(20, 1, 8'h70);
        rd(12'h404, "R7 partial"); pulse_evt();
        rd(12'h402, "R7 single frame kept");
        send(10, 1, 8'h80);
        pulse_evt();
        rd(12'h402, "R7 implied skip released");
        pulse_evt();
        rd(12'h402, "R7 unread frame kept");
        drain(1, "R7 drain");

        // R10 space and commitment
        cfg_keep_crc = 1;
        send(140, 1, 8'h90);
        rd(12'h402, "R10 oversized dropped");
        send(60, 1, 8'hA0);
        send(80, 1, 8'hB0);
        drain(0, "R10 held frame intact");
        send(80, 1, 8'hC0);
        drain(1, "R10 fits after release");

        // R11 descriptor slots
        cfg_keep_crc = 0;
        send(8, 1, 8'h01); send(9, 1, 8'h02); send(10, 1, 8'h03);
        drain(0, "R11 drain");

        // R13 early pulse suppressed while a frame is held
        cfg_early_irq_en = 1;
        send(12, 1, 8'h10);
        send(12, 1, 8'h12);
        drain(1, "R13 drain");
        cfg_early_irq_en = 0;

        // R12 interrupt disabled
        cfg_ok_irq_en = 0;
        send(16, 1, 8'h14);
        drain(0, "R12 drain");
        cfg_ok_irq_en = 1;

        // mixed traffic, pointers wrap many times
        for (int f = 0; f < 40; f++) begin
            cfg_keep_crc = f[0];
            send(5 + (f * 13) % 50, 1, f * 3);
            if (f % 3 == 0) begin
                send(6 + f % 7, 1, f * 5);
                rd(12'h404, "R4 mixed");
                pulse_evt();
            end
            drain(f[1], "R5 mixed");
        end

        rd(12'h400, "R1 idle at end");
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule